// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Controller

This block runs the external bus of a processor with a 16-bit address and an 8-bit data path. The low address byte and the data byte share one set of pins. The core asks for one machine cycle at a time: an instruction fetch, a data read, a data write or a halt, together with an address, write data and a memory/IO select. The controller steps through the clock states of that cycle. It places the low address on the shared lines in the first clock and strobes it into external latches. It then turns the same lines into the data path, drives active-low read and write strobes and reports the cycle type on a two-bit status code.

Slow devices stretch a cycle by holding `ready` low, and each low sample adds one wait state. Another bus master can ask for the buses with `hold`. The controller finishes the machine cycle in progress and then acknowledges with `hlda`. Half a clock later it releases every output that has a tristate control. The ones it keeps driving are the address strobe, the status code and the acknowledge. Tristating is expressed as separate output-enable signals, and the pad ring owns the actual three-state buffers.

Top module: `mux_bus_sequencer`

## Requirements
- R1: In the first clock of a read, write or fetch cycle, `ale` is high during the first half of the clock and low during the second half. Through that whole clock, `ad_out` holds address bits 7:0 with `ad_oe` high, and `addr_hi` holds address bits 15:8. `ale` has no enable and is always driven.
- R2: `st` carries the cycle code: 2'b00 halt, 2'b01 write, 2'b10 read, 2'b11 fetch. It takes the new code in the first clock of a cycle and holds it unchanged until the next cycle is taken.
- R3: `rd_n` goes low only for read and fetch cycles, and `wr_n` only for write cycles. Each is low only in the second clock, in any wait states and in the third clock. It is high in every other clock. `ad_oe` is low whenever `rd_n` is low.
- R4: In a write cycle, `ad_out` carries the write data with `ad_oe` high from the second clock onward. It stays there for one more clock after the third clock, while `wr_n` is already high again.
- R5: `ready` is sampled at the clock edge that ends the second clock and at the edge that ends each wait state. Every low sample adds exactly one wait state, so the strobe stays low for 2 + (number of low samples) clocks.
- R6: The clock after the third clock of any cycle, `done` is high for exactly one clock. In a read or fetch cycle, `rd_data` then holds the `ad_in` value sampled at the edge that ends the third clock.
- R7: `hold` is granted only at a cycle boundary, from the idle or halted state. `hlda` rises at the first edge at which the controller is in either of those states with `hold` high. A cycle already under way runs to its end first. While `hold` or `hlda` is high, no request is taken.
- R8: Half a clock after `hlda` rises, `addr_hi_oe`, `ad_oe`, `ctl_oe` (covering `rd_n` and `io_sel`) and `wr_oe` all go low. After `hold` falls, `hlda` drops at the next edge, and the enables return half a clock after that.
- R9: A halt request enters a halted state with `st` = 2'b00. In that state `addr_hi_oe`, `ad_oe` and `wr_oe` are low, and `ctl_oe` stays high. The state persists until a request of another kind is taken, which starts its first clock at the next edge.
- R10: After reset, `ale`, `hlda`, `done` and `ad_oe` are low. `rd_n` and `wr_n` are high, `st` is 2'b00 and `addr_hi_oe` is high.
- R11: `req_take` is high, combinationally, in a clock in which the controller is idle (or halted with a non-halt request), `req_valid` is high and `hold` is low. The request is latched at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Core presents a machine-cycle request |
| req_kind | input | 2 | Requested cycle: 00 halt, 01 write, 10 read, 11 fetch |
| req_addr | input | 16 | Address of the requested cycle |
| req_wdata | input | 8 | Write data |
| req_io | input | 1 | 1 selects IO space, 0 memory |
| req_take | output | 1 | Request accepted at this edge |
| done | output | 1 | One-clock pulse after a cycle's third clock |
| rd_data | output | 8 | Data captured by the last read or fetch |
| addr_hi | output | 8 | Upper address byte |
| addr_hi_oe | output | 1 | Enable for `addr_hi` |
| ad_out | output | 8 | Shared low address / data lines, outbound |
| ad_in | input | 8 | Shared low address / data lines, inbound |
| ad_oe | output | 1 | Enable for `ad_out` |
| ale | output | 1 | Address latch strobe |
| st | output | 2 | Cycle status code |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_sel | output | 1 | Memory/IO select of the current cycle |
| ctl_oe | output | 1 | Enable for `rd_n` and `io_sel` |
| wr_oe | output | 1 | Enable for `wr_n` |
| ready | input | 1 | Device ready; low adds wait states |
| hold | input | 1 | Another master requests the buses |
| hlda | output | 1 | Hold acknowledge |

## Verification
A request taken at one edge shows up at the pins from the next edge: first clock, address on the lines, `ale` high for half a clock. The strobe goes low one edge later and stays low for 2 + waits clocks. `done` and `rd_data` follow one edge after the strobe rises. Enables react half a clock after `hlda` changes. The bench drives inputs and reads outputs 2 ns after each rising edge, when registered outputs have settled. It reads `ale` and the enables a second time 6 ns after the edge, after the falling-edge flops have moved. The strobe-low clocks are counted rather than assumed, so a wait state too many or too few shows up as a mismatch of the count.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

  // Cycle codes double as the status pin encoding.
  typedef enum logic [1:0] {
    K_HALT  = 2'b00,
    K_WRITE = 2'b01,
    K_READ  = 2'b10,
    K_FETCH = 2'b11
  } bus_kind_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_T1,
    PH_T2,
    PH_TW,
    PH_T3,
    PH_HOLD,
    PH_HALT
  } phase_e;

endpackage

// File: rtl/mbs_phase_fsm.sv
module mbs_phase_fsm
  import mbs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_valid,
  input  logic [1:0] req_kind,
  input  logic      ready,
  input  logic      hold,
  output phase_e    phase,
  output logic      take
);

  phase_e ph_q, ph_nxt;
  logic   ph_en;

  always_comb begin
    ph_nxt = ph_q;
    take   = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (hold) begin
          ph_nxt = PH_HOLD;
        end else if (req_valid) begin
          take   = 1'b1;
          ph_nxt = (req_kind == K_HALT) ? PH_HALT : PH_T1;
        end
      end
      PH_T1:        ph_nxt = PH_T2;
      PH_T2, PH_TW: ph_nxt = ready ? PH_T3 : PH_TW;
      PH_T3:        ph_nxt = PH_IDLE;
      PH_HOLD: begin
        if (!hold) ph_nxt = PH_IDLE;
      end
      PH_HALT: begin
        if (hold) begin
          ph_nxt = PH_HOLD;
        end else if (req_valid && (req_kind != K_HALT)) begin
          take   = 1'b1;
          ph_nxt = PH_T1;
        end
      end
      default: ph_nxt = PH_IDLE;
    endcase
  end

  assign ph_en = (ph_nxt != ph_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;
    end else if (ph_en) begin
      ph_q <= ph_nxt;
    end
  end

  assign phase = ph_q;

endmodule

// File: rtl/mbs_req_hold.sv
module mbs_req_hold
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  phase_e            phase,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_io,
  input  logic [DATA_W-1:0] ad_in,
  output bus_kind_e         kind,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic              io,
  output logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic              wr_tail
);

  logic cap_en;
  logic last_clk;

  assign last_clk = (phase == PH_T3);
  assign cap_en   = last_clk && ((kind == K_READ) || (kind == K_FETCH));

  // request capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind  <= K_HALT;
      addr  <= '0;
      wdata <= '0;
      io    <= 1'b0;
    end else if (take) begin
      kind  <= bus_kind_e'(req_kind);
      addr  <= req_addr;
      wdata <= req_wdata;
      io    <= req_io;
    end
  end

  // read data capture at the end of the last clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (cap_en) begin
      rdata <= ad_in;
    end
  end

  // completion pulse and write-data tail
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      wr_tail <= 1'b0;
    end else begin
      done    <= last_clk;
      wr_tail <= last_clk && (kind == K_WRITE);
    end
  end

endmodule

// File: rtl/mbs_pin_drive.sv
module mbs_pin_drive
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase,
  input  bus_kind_e         kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              io,
  input  logic              wr_tail,
  output logic [HI_W-1:0]   addr_hi,
  output logic              addr_hi_oe,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic              ale,
  output logic [1:0]        st,
  output logic              rd_n,
  output logic              wr_n,
  output logic              io_sel,
  output logic              ctl_oe,
  output logic              wr_oe,
  output logic              hlda
);

  logic in_t1, in_data, is_wr, is_rd, halted;
  logic mid_q;    // set at the falling edge inside the first clock
  logic float_q;  // follows the acknowledge half a clock late

  assign in_t1   = (phase == PH_T1);
  assign in_data = (phase == PH_T2) || (phase == PH_TW) || (phase == PH_T3);
  assign is_wr   = (kind == K_WRITE);
  assign is_rd   = (kind == K_READ) || (kind == K_FETCH);
  assign halted  = (phase == PH_HALT);
  assign hlda    = (phase == PH_HOLD);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_q   <= 1'b0;
      float_q <= 1'b0;
    end else begin
      mid_q   <= in_t1;
      float_q <= hlda;
    end
  end

  assign ale        = in_t1 && !mid_q;
  assign st         = kind;
  assign addr_hi    = addr[ADDR_W-1:DATA_W];
  assign ad_out     = in_t1 ? addr[DATA_W-1:0] : wdata;
  assign rd_n       = !(in_data && is_rd);
  assign wr_n       = !(in_data && is_wr);
  assign io_sel     = io;

  assign addr_hi_oe = !float_q && !halted;
  assign ad_oe      = !float_q && (in_t1 || (is_wr && (in_data || wr_tail)));
  assign ctl_oe     = !float_q;
  assign wr_oe      = !float_q && !halted;

endmodule

// File: rtl/mux_bus_sequencer.sv
module mux_bus_sequencer
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_io,
  output logic              req_take,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [HI_W-1:0]   addr_hi,
  output logic              addr_hi_oe,
  output logic [DATA_W-1:0] ad_out,
  input  logic [DATA_W-1:0] ad_in,
  output logic              ad_oe,
  output logic              ale,
  output logic [1:0]        st,
  output logic              rd_n,
  output logic              wr_n,
  output logic              io_sel,
  output logic              ctl_oe,
  output logic              wr_oe,
  input  logic              ready,
  input  logic              hold,
  output logic              hlda
);

  logic [1:0]        rst_sync;
  logic              core_rst_n;
  phase_e            phase;
  bus_kind_e         cur_kind;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata;
  logic              cur_io;
  logic              wr_tail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign core_rst_n = rst_sync[1];

  mbs_phase_fsm u_fsm (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .req_valid(req_valid),
    .req_kind (req_kind),
    .ready    (ready),
    .hold     (hold),
    .phase    (phase),
    .take     (req_take)
  );

  mbs_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .take     (req_take),
    .phase    (phase),
    .req_kind (req_kind),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .req_io   (req_io),
    .ad_in    (ad_in),
    .kind     (cur_kind),
    .addr     (cur_addr),
    .wdata    (cur_wdata),
    .io       (cur_io),
    .rdata    (rd_data),
    .done     (done),
    .wr_tail  (wr_tail)
  );

  mbs_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .phase     (phase),
    .kind      (cur_kind),
    .addr      (cur_addr),
    .wdata     (cur_wdata),
    .io        (cur_io),
    .wr_tail   (wr_tail),
    .addr_hi   (addr_hi),
    .addr_hi_oe(addr_hi_oe),
    .ad_out    (ad_out),
    .ad_oe     (ad_oe),
    .ale       (ale),
    .st        (st),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .io_sel    (io_sel),
    .ctl_oe    (ctl_oe),
    .wr_oe     (wr_oe),
    .hlda      (hlda)
  );

endmodule

// File: rtl/mbs_checker.sv
module mbs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_take,
  input logic       hold,
  input logic       hlda,
  input logic       rd_n,
  input logic       wr_n,
  input logic       ad_oe,
  input logic       addr_hi_oe,
  input logic       ctl_oe,
  input logic       wr_oe,
  input logic [1:0] st,
  input logic       done
);

  // R3: never both strobes, and no drive while a device answers a read
  p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  p_rd_no_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  // R2: status does not move inside the strobe window
  p_status_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((!rd_n || !wr_n) && $past(!rd_n || !wr_n)) |-> $stable(st));

  // R6: completion follows a strobe clock
  p_done_after_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(!rd_n || !wr_n));

  // R7: acknowledge only from a boundary, and no take around a hold
  p_hlda_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hlda) |-> $past(rd_n && wr_n));
  p_take_no_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_take |-> (!hold && !hlda));

  // R8: one full clock into the acknowledge, all enables are off
  p_hold_float_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hlda && $past(hlda)) |-> (!addr_hi_oe && !ad_oe && !ctl_oe && !wr_oe));

endmodule

bind mux_bus_sequencer mbs_checker u_mbs_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_take  (req_take),
  .hold      (hold),
  .hlda      (hlda),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .ad_oe     (ad_oe),
  .addr_hi_oe(addr_hi_oe),
  .ctl_oe    (ctl_oe),
  .wr_oe     (wr_oe),
  .st        (st),
  .done      (done)
);

// File: tb/tb_mux_bus_sequencer.sv
`timescale 1ns/1ps
module tb_mux_bus_sequencer;

  logic       clk;
  logic       rst_n;
  logic       req_valid;
  logic [1:0] req_kind;
  logic [15:0] req_addr;
  logic [7:0] req_wdata;
  logic       req_io;
  logic       req_take;
  logic       done;
  logic [7:0] rd_data;
  logic [7:0] addr_hi;
  logic       addr_hi_oe;
  logic [7:0] ad_out;
  logic [7:0] ad_in;
  logic       ad_oe;
  logic       ale;
  logic [1:0] st;
  logic       rd_n;
  logic       wr_n;
  logic       io_sel;
  logic       ctl_oe;
  logic       wr_oe;
  logic       ready;
  logic       hold;
  logic       hlda;

  int total = 0;
  int fails = 0;

  mux_bus_sequencer dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_io(req_io),
    .req_take(req_take), .done(done), .rd_data(rd_data), .addr_hi(addr_hi),
    .addr_hi_oe(addr_hi_oe), .ad_out(ad_out), .ad_in(ad_in), .ad_oe(ad_oe),
    .ale(ale), .st(st), .rd_n(rd_n), .wr_n(wr_n), .io_sel(io_sel),
    .ctl_oe(ctl_oe), .wr_oe(wr_oe), .ready(ready), .hold(hold), .hlda(hlda)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  // {kind[2], io, addr[16], wdata[8], read value[8], waits[3]}
  localparam logic [37:0] VECS [0:5] = '{
    {2'b11, 1'b0, 16'h1234, 8'h00, 8'h3E, 3'd0},
    {2'b10, 1'b0, 16'hA5C3, 8'h00, 8'h81, 3'd2},
    {2'b01, 1'b0, 16'h00FF, 8'h5A, 8'h00, 3'd0},
    {2'b01, 1'b1, 16'h7F10, 8'hC3, 8'h00, 3'd3},
    {2'b10, 1'b1, 16'h00FE, 8'h00, 8'h00, 3'd1},
    {2'b11, 1'b0, 16'hFFFF, 8'h00, 8'hFF, 3'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  // Starts at 2 ns after an edge with the controller idle or halted.
  task automatic run_cycle(input logic [1:0] kind, input logic io, input logic [15:0] addr,
                           input logic [7:0] wd, input logic [7:0] rdin, input int nw);
    int lowcnt;
    req_kind  = kind;
    req_io    = io;
    req_addr  = addr;
    req_wdata = wd;
    req_valid = 1'b1;
    #1;
    chk("R11 take", req_take, 1);
    step();
    req_valid = 1'b0;
    chk("R1 ale first half", ale, 1);
    chk("R1 low address", ad_out, addr[7:0]);
    chk("R1 ad drive", ad_oe, 1);
    chk("R1 high address", addr_hi, addr[15:8]);
    chk("R2 status", st, kind);
    chk("R3 no strobe in first clock", {rd_n, wr_n}, 2'b11);
    chk("R2 io select", io_sel, io);
    #4;
    chk("R1 ale second half", ale, 0);
    chk("R1 address held", ad_out, addr[7:0]);
    lowcnt = 0;
    step();
    while ((!rd_n || !wr_n) && lowcnt < 20) begin
      lowcnt++;
      chk("R2 status held", st, kind);
      if (kind == 2'b01) begin
        chk("R3 write strobe only", {rd_n, wr_n}, 2'b10);
        chk("R4 write data", ad_out, wd);
        chk("R4 write drive", ad_oe, 1);
      end else begin
        chk("R3 read strobe only", {rd_n, wr_n}, 2'b01);
        chk("R3 released for read", ad_oe, 0);
        ad_in = rdin;
      end
      ready = (lowcnt > nw);
      step();
    end
    ready = 1'b1;
    chk("R5 strobe clocks", lowcnt, nw + 2);
    chk("R6 done", done, 1);
    if (kind == 2'b01) begin
      chk("R4 data after strobe", ad_out, wd);
      chk("R4 drive after strobe", ad_oe, 1);
    end else begin
      chk("R6 read data", rd_data, rdin);
    end
    ad_in = 8'h00;
    step();
    chk("R6 done one clock", done, 0);
  endtask

  initial begin
    #(8 * 100000);
    total++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_kind  = 2'b00;
    req_addr  = 16'h0000;
    req_wdata = 8'h00;
    req_io    = 1'b0;
    ad_in     = 8'h00;
    ready     = 1'b1;
    hold      = 1'b0;
    step();
    step();
    // R10 reset state
    chk("R10 ale", ale, 0);
    chk("R10 hlda", hlda, 0);
    chk("R10 done", done, 0);
    chk("R10 ad_oe", ad_oe, 0);
    chk("R10 strobes", {rd_n, wr_n}, 2'b11);
    chk("R10 status", st, 2'b00);
    chk("R10 addr_hi_oe", addr_hi_oe, 1);
    rst_n = 1'b1;
    step();
    step();
    step();

    // table walk: R1..R6, R11
    for (int i = 0; i < 6; i++) begin
      logic [37:0] e;
      e = VECS[i];
      run_cycle(e[37:36], e[35], e[34:19], e[18:11], e[10:3], int'(e[2:0]));
    end

    // R5: ready low in the first clock has no effect
    ready = 1'b0;
    req_kind = 2'b10; req_addr = 16'h2222; req_valid = 1'b1;
    step();
    req_valid = 1'b0;
    ready = 1'b1;
    step();
    chk("R5 ready ignored in first clock", rd_n, 0);
    step();
    chk("R5 no wait when sampled high", rd_n, 0);
    step();
    chk("R5 cycle ended", rd_n, 1);
    step();

    // R7, R8: hold during a cycle
    req_kind = 2'b10; req_addr = 16'h4321; req_io = 1'b0; req_valid = 1'b1;
    step();
    req_valid = 1'b0;
    step();
    hold = 1'b1;
    chk("R7 cycle continues", rd_n, 0);
    step();
    chk("R7 no ack in last clock", hlda, 0);
    chk("R7 strobe still low", rd_n, 0);
    step();
    chk("R7 no ack at boundary edge", hlda, 0);
    chk("R7 done of held cycle", done, 1);
    step();
    chk("R7 ack", hlda, 1);
    chk("R8 enables before half clock", ctl_oe, 1);
    #4;
    chk("R8 addr float", addr_hi_oe, 0);
    chk("R8 ad float", ad_oe, 0);
    chk("R8 ctl float", ctl_oe, 0);
    chk("R8 wr float", wr_oe, 0);
    chk("R1 ale still driven low", ale, 0);
    req_kind = 2'b11; req_addr = 16'h0800; req_valid = 1'b1;
    step();
    chk("R7 no take during hold", req_take, 0);
    chk("R7 ack held", hlda, 1);
    hold = 1'b0;
    step();
    chk("R8 ack drops", hlda, 0);
    chk("R8 still floating", ctl_oe, 0);
    chk("R11 take after release", req_take, 1);
    #4;
    chk("R8 retaken ctl", ctl_oe, 1);
    chk("R8 retaken addr", addr_hi_oe, 1);
    chk("R8 retaken wr", wr_oe, 1);
    step();
    req_valid = 1'b0;
    chk("R1 pending fetch starts", ale, 1);
    chk("R2 pending fetch status", st, 2'b11);
    step(); step(); step();
    chk("R6 pending fetch done", done, 1);
    step();

    // R9: halt
    req_kind = 2'b00; req_addr = 16'h9999; req_valid = 1'b1;
    #1;
    chk("R11 halt take", req_take, 1);
    step();
    req_valid = 1'b0;
    chk("R9 status", st, 2'b00);
    chk("R9 addr float", addr_hi_oe, 0);
    chk("R9 ad float", ad_oe, 0);
    chk("R9 wr float", wr_oe, 0);
    chk("R9 rd kept", ctl_oe, 1);
    chk("R9 no ale", ale, 0);
    step();
    chk("R9 stays halted", addr_hi_oe, 0);
    chk("R9 no strobe", {rd_n, wr_n}, 2'b11);
    run_cycle(2'b11, 1'b0, 16'h0100, 8'h00, 8'h76, 0);
    chk("R9 drive restored", addr_hi_oe, 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule